// File: doc/BRIEF.md
# Embedded Interval Timer Unit

This block supplies two periodic events to an embedded processor core. A 32-bit interval counter is loaded by software and counts down once per timebase tick enable. When it runs out it flags a status bit and, if enabled, raises a level interrupt. A second, fixed-period event is taken from a selectable bit of an external timebase value. Each rising edge of that bit flags a second status bit, which can also raise a level interrupt.

Software reaches the block through three single-cycle write strobes: one for the control word, one for the status word and one for the interval reload value. Three read buses always show the control word, the status word and the live interval count. Status bits are cleared by writing ones. The interval counter is restarted or stopped from the reload value, the interrupt enable and the auto-reload setting. This is decided again on every control write and every reload write.

Top module: `emb_tmr_unit`

## Requirements
- R1: A reload write of N (N > 1) while control bit 26 (interval interrupt enable) is 1 loads the count with N on the next cycle. Each later tick enable then lowers the count by one, as seen on `pit_rdata`.
- R2: A tick enable that finds a running count of 1 sets status bit 27 (interval status) at that same clock edge.
- R3: A reload write of 0 or 1, or any reload write while control bit 26 is 0, leaves the counter stopped. Ticks then change neither the count nor status bit 27.
- R4: On expiry with control bit 22 (auto-reload) set, the count returns to the reload value at the same edge, so successive expiries are exactly N ticks apart. With bit 22 clear, the count stays at 0 and the counter stops.
- R5: A control write keeps bits [31:22] and reads zero in bits [21:0]. After the write the counter runs only if reload > 1, bit 26 = 1 and bit 22 = 1. A running counter keeps its count. A stopped counter restarts from the reload value.
- R6: Control bits [25:24] = s select timebase bit FIT_BASE + s*FIT_STEP (bits 3, 5, 7, 9 by default). A rising edge of the selected bit sets status bit 26 (fixed-interval status). A falling edge, or an edge on a bit that is not selected, does not set it.
- R7: A status write clears every bit of [31:26] written as 1 and leaves bits written as 0 unchanged. If a set event and a clear of the same bit happen in the same cycle, the set wins.
- R8: `pit_irq` equals status bit 27 AND control bit 26. `fit_irq` equals status bit 26 AND control bit 23. Clearing a status bit drops its interrupt after that clock edge.
- R9: With `rst_n` low at a clock edge, the control word, status word, reload value and count all become zero, and both interrupts are low.
- R10: In a cycle with a reload write or a control write, the tick enable has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timebase tick enable for the interval counter |
| tb_value | input | TB_W | Timebase value supplying the fixed-interval taps |
| tcr_wr_en | input | 1 | Control word write strobe |
| tcr_wdata | input | 32 | Control word write data |
| tcr_rdata | output | 32 | Control word readback |
| tsr_wr_en | input | 1 | Status word write strobe (write ones to clear) |
| tsr_wdata | input | 32 | Status word clear mask |
| tsr_rdata | output | 32 | Status word readback |
| pit_wr_en | input | 1 | Reload value write strobe |
| pit_wdata | input | 32 | Reload value |
| pit_rdata | output | 32 | Live interval count |
| pit_irq | output | 1 | Interval interrupt level |
| fit_irq | output | 1 | Fixed-interval interrupt level |

## Verification
The bench checks the expiry edge itself. It confirms that an auto-reloading count is back at N on the very tick that expires it and reads 1 again exactly N-1 ticks later. A design that counted the expiry tick twice would drift by a tick each period. The stop rules are driven with reload values of 0 and 1, and with the enable or auto-reload bit dropped while the counter runs. A design that started on these values would raise status that software never asked for. Ticks that land in the same cycle as a write are checked as well, and so is a clear that meets a set event in the same cycle. A design that let the clear win would lose an interrupt. The fixed-interval tap is checked for edges on a bit that is not selected and for falling edges, which must not set status.

// File: rtl/emb_tmr_pkg.sv
// Package: shared bit positions and widths of the timer unit registers.
// Assumes 32-bit control and status words; positions are fixed because
// software decodes them.
package emb_tmr_pkg;
    localparam int REG_W        = 32;
    localparam int CTL_PIT_IE   = 26;   // interval interrupt enable
    localparam int CTL_SEL_HI   = 25;   // fixed-interval tap select, high bit
    localparam int CTL_SEL_LO   = 24;   // fixed-interval tap select, low bit
    localparam int CTL_FIT_IE   = 23;   // fixed-interval interrupt enable
    localparam int CTL_AUTO     = 22;   // auto-reload
    localparam int CTL_KEEP_LO  = 22;   // lowest stored control bit
    localparam int STS_LO       = 26;   // lowest status bit
    localparam int STS_W        = REG_W - STS_LO;
    localparam int STS_PIT_IDX  = 27 - STS_LO;
    localparam int STS_FIT_IDX  = 26 - STS_LO;
    localparam int FIT_TAPS     = 4;
    localparam logic [REG_W-1:0] CTL_MASK = {{(REG_W-CTL_KEEP_LO){1'b1}}, {CTL_KEEP_LO{1'b0}}};
endpackage

// File: rtl/emb_tmr_pit.sv
// Module: interval down-counter with reload, run/stop rules and expiry pulse.
// Assumes the caller supplies the current enable/auto-reload bits and, on a
// control write, the bits being written. Writes take priority over ticks.
module emb_tmr_pit #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ctl_wr,
    input  logic             ctl_ie,
    input  logic             ctl_auto,
    input  logic             cur_ie,
    input  logic             cur_auto,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             load_ok;
    logic             ctl_ok;

    // Run conditions for a reload write and for a control write.
    always_comb begin
        load_ok = (load_val > CNT_W'(1)) && cur_ie;
        ctl_ok  = (reload_q > CNT_W'(1)) && ctl_ie && ctl_auto;
    end

    // Expiry: a tick meets a running count of one, with no write pending.
    assign expire = run_q && tick && !load_wr && !ctl_wr && (cnt_q == CNT_W'(1));
    assign count  = cnt_q;

    // Counter state: reload value, count and run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
            run_q    <= 1'b0;
        end else if (load_wr) begin
            reload_q <= load_val;
            if (load_ok) begin
                cnt_q <= load_val;
                run_q <= 1'b1;
            end else begin
                run_q <= 1'b0;
            end
        end else if (ctl_wr) begin
            if (ctl_ok) begin
                if (!run_q) cnt_q <= reload_q;
                run_q <= 1'b1;
            end else begin
                run_q <= 1'b0;
            end
        end else if (run_q && tick) begin
            if (cnt_q == CNT_W'(1)) begin
                if (cur_auto) begin
                    cnt_q <= reload_q;
                end else begin
                    cnt_q <= '0;
                    run_q <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    AST_PIT_SMALL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr && (load_val <= CNT_W'(1)) |=> !run_q);  // R3
    AST_PIT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && tick && !load_wr && !ctl_wr && (cnt_q > CNT_W'(1))
        |=> cnt_q == $past(cnt_q) - CNT_W'(1));  // R1
    AST_PIT_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        expire && cur_auto |=> run_q && (cnt_q == $past(reload_q)));  // R4
    AST_PIT_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !cur_auto |=> !run_q && (cnt_q == '0));  // R4
    AST_PIT_WRITE_BLOCKS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !load_wr && run_q && ctl_ok |=> $stable(cnt_q));  // R10
endmodule

// File: rtl/emb_tmr_fit.sv
// Module: fixed-interval tap selector with rising-edge detection.
// Assumes FIT_BASE + 3*FIT_STEP < TB_W; the tap is sampled every clock.
module emb_tmr_fit #(
    parameter int TB_W     = 16,
    parameter int FIT_BASE = 3,
    parameter int FIT_STEP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TB_W-1:0] tb_value,
    input  logic [1:0]      sel,
    output logic            rise
);
    import emb_tmr_pkg::*;

    logic [FIT_TAPS-1:0] taps;
    logic                tap_now;
    logic                tap_q;
    logic                unused_tb;

    // One candidate tap per select code.
    for (genvar g = 0; g < FIT_TAPS; g++) begin : g_tap
        assign taps[g] = tb_value[FIT_BASE + g*FIT_STEP];
    end

    assign unused_tb = ^tb_value;
    assign tap_now   = taps[sel];
    assign rise      = tap_now && !tap_q;

    // Previous value of the selected tap.
    always_ff @(posedge clk) begin
        if (!rst_n) tap_q <= 1'b0;
        else        tap_q <= tap_now;
    end
endmodule

// File: rtl/emb_tmr_status.sv
// Module: status flags with set events and write-one-to-clear.
// Assumes set events win over a clear of the same bit in the same cycle.
module emb_tmr_status (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_pit,
    input  logic                        set_fit,
    input  logic                        clr_wr,
    input  logic [emb_tmr_pkg::STS_W-1:0] clr_mask,
    output logic [emb_tmr_pkg::STS_W-1:0] sts
);
    import emb_tmr_pkg::*;

    logic [STS_W-1:0] sts_q;
    logic [STS_W-1:0] set_vec;
    logic [STS_W-1:0] clr_vec;

    // Set and clear vectors for this cycle.
    always_comb begin
        set_vec              = '0;
        set_vec[STS_PIT_IDX] = set_pit;
        set_vec[STS_FIT_IDX] = set_fit;
        clr_vec              = clr_wr ? clr_mask : '0;
    end

    // Flag register: clear first, then set.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~clr_vec) | set_vec;
    end

    assign sts = sts_q;

    AST_STS_PIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_pit |=> sts_q[STS_PIT_IDX]);  // R2
    AST_STS_FIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_fit |=> sts_q[STS_FIT_IDX]);  // R6
    AST_STS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && clr_mask[STS_PIT_IDX] && !set_pit |=> !sts_q[STS_PIT_IDX]);  // R7
    AST_STS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && !clr_mask[STS_FIT_IDX] && sts_q[STS_FIT_IDX] |=> sts_q[STS_FIT_IDX]);  // R7
endmodule

// File: rtl/emb_tmr_unit.sv
// Module: timer unit top. Holds the control word, wires the interval
// counter, fixed-interval tap and status flags, and forms the interrupts.
// Assumes single-cycle write strobes and a synchronous active-low reset.
module emb_tmr_unit #(
    parameter int TB_W     = 16,
    parameter int FIT_BASE = 3,
    parameter int FIT_STEP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic [TB_W-1:0] tb_value,
    input  logic            tcr_wr_en,
    input  logic [31:0]     tcr_wdata,
    output logic [31:0]     tcr_rdata,
    input  logic            tsr_wr_en,
    input  logic [31:0]     tsr_wdata,
    output logic [31:0]     tsr_rdata,
    input  logic            pit_wr_en,
    input  logic [31:0]     pit_wdata,
    output logic [31:0]     pit_rdata,
    output logic            pit_irq,
    output logic            fit_irq
);
    import emb_tmr_pkg::*;

    logic [REG_W-1:0] tcr_q;
    logic [STS_W-1:0] sts;
    logic             pit_expire;
    logic             fit_rise;
    logic             unused_tsr;

    // Control word register; only the upper bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)         tcr_q <= '0;
        else if (tcr_wr_en) tcr_q <= tcr_wdata & CTL_MASK;
    end

    emb_tmr_pit #(.CNT_W(REG_W)) pit_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .load_wr  (pit_wr_en),
        .load_val (pit_wdata),
        .ctl_wr   (tcr_wr_en),
        .ctl_ie   (tcr_wdata[CTL_PIT_IE]),
        .ctl_auto (tcr_wdata[CTL_AUTO]),
        .cur_ie   (tcr_q[CTL_PIT_IE]),
        .cur_auto (tcr_q[CTL_AUTO]),
        .count    (pit_rdata),
        .expire   (pit_expire)
    );

    emb_tmr_fit #(.TB_W(TB_W), .FIT_BASE(FIT_BASE), .FIT_STEP(FIT_STEP)) fit_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tb_value (tb_value),
        .sel      (tcr_q[CTL_SEL_HI:CTL_SEL_LO]),
        .rise     (fit_rise)
    );

    emb_tmr_status sts_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_pit  (pit_expire),
        .set_fit  (fit_rise),
        .clr_wr   (tsr_wr_en),
        .clr_mask (tsr_wdata[REG_W-1:STS_LO]),
        .sts      (sts)
    );

    assign unused_tsr = ^tsr_wdata[STS_LO-1:0];
    assign tcr_rdata  = tcr_q;
    assign tsr_rdata  = {sts, {STS_LO{1'b0}}};
    assign pit_irq    = sts[STS_PIT_IDX] & tcr_q[CTL_PIT_IE];
    assign fit_irq    = sts[STS_FIT_IDX] & tcr_q[CTL_FIT_IE];

    AST_IRQ_DROPS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        tsr_wr_en && tsr_wdata[27] && !pit_expire |=> !pit_irq);  // R8
    AST_IRQ_FIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tcr_wr_en && !tcr_wdata[CTL_FIT_IE] |=> !fit_irq);  // R8
endmodule

// File: tb/emb_tmr_unit_tb_top.sv
// Directed bench for the timer unit: one task per scenario.
module emb_tmr_unit_tb_top;
    localparam int TB_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick_en = 1'b0;
    logic [TB_W-1:0] tb_value = '0;
    logic            tcr_wr_en = 1'b0;
    logic [31:0]     tcr_wdata = '0;
    logic [31:0]     tcr_rdata;
    logic            tsr_wr_en = 1'b0;
    logic [31:0]     tsr_wdata = '0;
    logic [31:0]     tsr_rdata;
    logic            pit_wr_en = 1'b0;
    logic [31:0]     pit_wdata = '0;
    logic [31:0]     pit_rdata;
    logic            pit_irq;
    logic            fit_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] IE_AR  = 32'h0440_0000;
    localparam logic [31:0] IE_ONL = 32'h0400_0000;
    localparam logic [31:0] ST_PIT = 32'h0800_0000;
    localparam logic [31:0] ST_FIT = 32'h0400_0000;

    always #2.5 clk = ~clk;

    emb_tmr_unit #(.TB_W(TB_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tb_value(tb_value),
        .tcr_wr_en(tcr_wr_en), .tcr_wdata(tcr_wdata), .tcr_rdata(tcr_rdata),
        .tsr_wr_en(tsr_wr_en), .tsr_wdata(tsr_wdata), .tsr_rdata(tsr_rdata),
        .pit_wr_en(pit_wr_en), .pit_wdata(pit_wdata), .pit_rdata(pit_rdata),
        .pit_irq(pit_irq), .fit_irq(fit_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic wr_tcr(input logic [31:0] v);
        tcr_wr_en = 1'b1; tcr_wdata = v;
        @(negedge clk);
        tcr_wr_en = 1'b0;
    endtask

    task automatic wr_tsr(input logic [31:0] v);
        tsr_wr_en = 1'b1; tsr_wdata = v;
        @(negedge clk);
        tsr_wr_en = 1'b0;
    endtask

    task automatic wr_pit(input logic [31:0] v);
        pit_wr_en = 1'b1; pit_wdata = v;
        @(negedge clk);
        pit_wr_en = 1'b0;
    endtask

    task automatic set_tb(input logic [TB_W-1:0] v);
        tb_value = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R9 control", tcr_rdata, 32'h0);
        chk("R9 status", tsr_rdata, 32'h0);
        chk("R9 count", pit_rdata, 32'h0);
        chk("R9 irqs", {30'h0, pit_irq, fit_irq}, 32'h0);
    endtask

    task automatic t_autoreload;
        wr_tcr(IE_AR | 32'h003F_FFFF);
        chk("R5 low bits zero", tcr_rdata, IE_AR);
        wr_pit(32'd5);
        chk("R1 load", pit_rdata, 32'd5);
        ticks(2);
        chk("R1 count down", pit_rdata, 32'd3);
        ticks(2);
        chk("R1 count at one", pit_rdata, 32'd1);
        chk("R2 no status before expiry", tsr_rdata, 32'h0);
        ticks(1);
        chk("R4 reload on expiry", pit_rdata, 32'd5);
        chk("R2 status on expiry", tsr_rdata, ST_PIT);
        chk("R8 pit irq high", {31'h0, pit_irq}, 32'd1);
        ticks(4);
        chk("R4 exact period", pit_rdata, 32'd1);
        ticks(1);
        chk("R4 second reload", pit_rdata, 32'd5);
    endtask

    task automatic t_clear;
        wr_tsr(ST_FIT);
        chk("R7 zero bit kept", tsr_rdata, ST_PIT);
        wr_tsr(ST_PIT);
        chk("R7 one bit cleared", tsr_rdata, 32'h0);
        chk("R8 pit irq drops", {31'h0, pit_irq}, 32'd0);
    endtask

    task automatic t_oneshot;
        wr_tcr(IE_ONL);
        chk("R5 auto-reload off stops", pit_rdata, 32'd5);
        ticks(2);
        chk("R5 stopped count holds", pit_rdata, 32'd5);
        wr_pit(32'd3);
        chk("R1 reload write starts", pit_rdata, 32'd3);
        ticks(3);
        chk("R4 one-shot to zero", pit_rdata, 32'd0);
        chk("R2 one-shot status", tsr_rdata, ST_PIT);
        ticks(2);
        chk("R4 holds at zero", pit_rdata, 32'd0);
    endtask

    task automatic t_stop_rules;
        wr_tsr(32'hFC00_0000);
        chk("R7 clear all", tsr_rdata, 32'h0);
        wr_pit(32'd1);
        ticks(3);
        chk("R3 reload one stays", pit_rdata, 32'd0);
        chk("R3 reload one no status", tsr_rdata, 32'h0);
        wr_pit(32'd0);
        ticks(2);
        chk("R3 reload zero no status", tsr_rdata, 32'h0);
        wr_tcr(32'h0);
        wr_pit(32'd4);
        ticks(6);
        chk("R3 disabled no count", pit_rdata, 32'd0);
        chk("R3 disabled no status", tsr_rdata, 32'h0);
    endtask

    task automatic t_restart_priority;
        wr_tcr(IE_AR);
        chk("R5 restart from reload", pit_rdata, 32'd4);
        ticks(1);
        chk("R1 after restart", pit_rdata, 32'd3);
        tick_en = 1'b1; tcr_wr_en = 1'b1; tcr_wdata = IE_AR;
        @(negedge clk);
        tick_en = 1'b0; tcr_wr_en = 1'b0;
        chk("R10 control write blocks tick", pit_rdata, 32'd3);
        tick_en = 1'b1; pit_wr_en = 1'b1; pit_wdata = 32'd6;
        @(negedge clk);
        tick_en = 1'b0; pit_wr_en = 1'b0;
        chk("R10 reload write wins", pit_rdata, 32'd6);
        ticks(1);
        wr_tcr(IE_AR);
        chk("R5 running keeps count", pit_rdata, 32'd5);
        wr_tcr(32'h0);
        ticks(2);
        chk("R5 enable off stops", pit_rdata, 32'd5);
    endtask

    task automatic t_fit;
        set_tb(16'h0008);
        chk("R6 tap 3 rise sets", tsr_rdata, ST_FIT);
        chk("R8 fit irq gated off", {31'h0, fit_irq}, 32'd0);
        wr_tcr(32'h0080_0000);
        chk("R8 fit irq on enable", {31'h0, fit_irq}, 32'd1);
        wr_tsr(ST_FIT);
        chk("R8 fit irq drops", {31'h0, fit_irq}, 32'd0);
        wr_tcr(32'h0280_0000);
        set_tb(16'h0000);
        set_tb(16'h0008);
        chk("R6 unselected tap ignored", tsr_rdata, 32'h0);
        set_tb(16'h0088);
        chk("R6 tap 7 rise sets", tsr_rdata, ST_FIT);
        wr_tsr(ST_FIT);
        set_tb(16'h0008);
        chk("R6 falling edge ignored", tsr_rdata, 32'h0);
        tb_value = 16'h0080; tsr_wr_en = 1'b1; tsr_wdata = ST_FIT;
        @(negedge clk);
        tsr_wr_en = 1'b0;
        chk("R7 set wins over clear", tsr_rdata, ST_FIT);
        chk("R8 fit irq level", {31'h0, fit_irq}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_autoreload();
        t_clear();
        t_oneshot();
        t_stop_rules();
        t_restart_priority();
        t_fit();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule